// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block holds the 8-bit accumulator and its carry and half-carry flags for a small microcontroller datapath, and updates them from a 4-bit operation code and an 8-bit operand. It performs binary add with and without carry-in, subtract with carry (where the carry flag means "no borrow"), the bitwise logic operations, clear, increment, decrement, rotates through carry, nibble swap, forcing the flags, and a decimal adjust that turns the result of a packed-BCD add or subtract into valid BCD.

The accumulator and flags are registered. They change on a rising clock edge only when the write-enable input is high. A registered direction bit records whether the last carry-using arithmetic was an add or a subtract. The decimal adjust uses that bit to choose between adding and removing the correction constants. Instruction fetch, operand fetch and skip decisions belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: After asynchronous reset (rst_ni low) the accumulator reads 0x00, both flags read 0, and the decimal-adjust direction is "add".
- R2: When we_i is low, or op_i is 15 (no operation), the accumulator, the flags and the adjust direction keep their values across the clock edge.
- R3: Op 0 (plain add) writes A+operand modulo 256. Op 7 (increment) writes A+1 and op 8 (decrement) writes A-1, both wrapping. None of the three changes either flag.
- R4: Op 1 (add with carry) writes A+operand+C, sets C to the carry out of bit 7, sets HC to the carry out of bit 3, and selects "add" for a later decimal adjust.
- R5: Op 2 (subtract with carry) writes A-operand-(1-C), sets C to 1 when no borrow out of bit 7 occurs, sets HC to 1 when no borrow out of bit 3 occurs, and selects "subtract" for a later decimal adjust.
- R6: Ops 3, 4 and 5 write A AND, OR and XOR operand. Op 6 writes 0x00. None of them changes either flag.
- R7: Op 9 (rotate right) loads A7 from the old C, shifts the other bits one place toward bit 0, loads C from the old A0, and leaves HC unchanged.
- R8: Op 10 (rotate left) loads A0 from the old C, shifts the other bits one place toward bit 7, loads C from the old A7, and loads HC from the old A0.
- R9: Op 11 exchanges the upper and lower nibbles of A and leaves the flags unchanged.
- R10: Op 12 sets both C and HC to 1. Op 13 clears both. Neither changes A.
- R11: Op 14 after an add adds 0x06 when HC is 1 or the low nibble exceeds 9. It adds 0x60 when C is 1 or A exceeds 0x99, and in that case also sets C. HC is unchanged.
- R12: Op 14 after a subtract removes 0x06 when HC is 0 and removes 0x60 when C is 0. It leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable for accumulator and flags |
| op_i | input | 4 | Operation code (0..15, see requirements) |
| operand_i | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator value |
| carry_o | output | 1 | Carry flag C |
| half_o | output | 1 | Half-carry flag HC |

## Verification
The arithmetic is driven with operand pairs that produce a carry out of bit 7 together with a carry out of bit 3, pairs that produce neither, and subtractions with and without borrow, so that each flag is shown to follow its own bit position. The decimal adjust is run after an add whose low nibble is out of range, after an add that sets only HC, after an add that overflows past 99, and after subtractions with and without borrow. Together these cases separate the low and high corrections and the add and subtract directions. The rotates are run twice in a row with different starting carries, which shows the old carry entering the vacated bit and HC picking up A0 only on the left rotate. The logic operations start with both flags set, which shows that they leave the flags alone.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUBC = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_CLR  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_RLC  = 4'd10,
    OP_SWAP = 4'd11,
    OP_SC   = 4'd12,
    OP_RC   = 4'd13,
    OP_DCOR = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] acc;
    logic              c;
    logic              h;
  } alu_res_t;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W   = 8,
  parameter int LOW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o,
  output logic         hco_o
);
  logic [W:0]   full;
  logic [LOW:0] low;

  always_comb begin
    full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
    low   = {1'b0, a_i[LOW-1:0]} + {1'b0, b_i[LOW-1:0]} + {{LOW{1'b0}}, ci_i};
    sum_o = full[W-1:0];
    co_o  = full[W];
    hco_o = low[LOW];
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic              c_i,
  input  logic              h_i,
  output alu_res_t          res_o
);
  always_comb begin
    res_o = '{acc: acc_i, c: c_i, h: h_i};
    unique case (op_i)
      OP_AND:  res_o.acc = acc_i & opd_i;
      OP_OR:   res_o.acc = acc_i | opd_i;
      OP_XOR:  res_o.acc = acc_i ^ opd_i;
      OP_CLR:  res_o.acc = '0;
      OP_RRC: begin
        res_o.acc = {c_i, acc_i[DATA_W-1:1]};
        res_o.c   = acc_i[0];
      end
      OP_RLC: begin
        res_o.acc = {acc_i[DATA_W-2:0], c_i};
        res_o.c   = acc_i[DATA_W-1];
        res_o.h   = acc_i[0];
      end
      OP_SWAP: res_o.acc = {acc_i[NIB_W-1:0], acc_i[DATA_W-1:NIB_W]};
      OP_SC: begin
        res_o.c = 1'b1;
        res_o.h = 1'b1;
      end
      OP_RC: begin
        res_o.c = 1'b0;
        res_o.h = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_dcor.sv
module acc_alu_dcor
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] acc_i,
  input  logic              c_i,
  input  logic              h_i,
  input  logic              sub_i,
  output alu_res_t          res_o
);
  localparam logic [NIB_W-1:0] SIX  = NIB_W'(6);
  localparam logic [NIB_W-1:0] NINE = NIB_W'(9);
  localparam logic [DATA_W-1:0] MAX_BCD = {NINE, NINE};

  logic lo_fix, hi_fix;
  logic [DATA_W-1:0] adj;

  always_comb begin
    if (sub_i) begin
      // no-borrow flags: correct where a borrow happened
      lo_fix = ~h_i;
      hi_fix = ~c_i;
    end else begin
      lo_fix = h_i | (acc_i[NIB_W-1:0] > NINE);
      hi_fix = c_i | (acc_i > MAX_BCD);
    end
    adj = {hi_fix ? SIX : '0, lo_fix ? SIX : '0};
    res_o.h   = h_i;
    res_o.acc = sub_i ? acc_i - adj : acc_i + adj;
    res_o.c   = sub_i ? c_i : (c_i | hi_fix);
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              half_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] acc_q;
  logic              c_q, h_q, sub_q;

  logic [DATA_W-1:0] add_b, add_sum;
  logic              add_ci, add_co, add_hco;
  alu_res_t          bit_res, dec_res, nxt;
  logic              sub_d;

  assign op = alu_op_e'(op_i);

  always_comb begin
    add_b  = operand_i;
    add_ci = 1'b0;
    unique case (op)
      OP_ADC:  add_ci = c_q;
      OP_SUBC: begin
        add_b  = ~operand_i;
        add_ci = c_q;
      end
      OP_INC: begin
        add_b  = '0;
        add_ci = 1'b1;
      end
      OP_DEC:  add_b = '1;
      default: ;
    endcase
  end

  acc_alu_adder #(.W(DATA_W), .LOW(NIB_W)) u_adder (
    .a_i   (acc_q),
    .b_i   (add_b),
    .ci_i  (add_ci),
    .sum_o (add_sum),
    .co_o  (add_co),
    .hco_o (add_hco)
  );

  acc_alu_bitops u_bitops (
    .op_i  (op),
    .acc_i (acc_q),
    .opd_i (operand_i),
    .c_i   (c_q),
    .h_i   (h_q),
    .res_o (bit_res)
  );

  acc_alu_dcor u_dcor (
    .acc_i (acc_q),
    .c_i   (c_q),
    .h_i   (h_q),
    .sub_i (sub_q),
    .res_o (dec_res)
  );

  always_comb begin
    nxt   = '{acc: acc_q, c: c_q, h: h_q};
    sub_d = sub_q;
    unique case (op)
      OP_ADD, OP_INC, OP_DEC: nxt.acc = add_sum;
      OP_ADC, OP_SUBC: begin
        nxt   = '{acc: add_sum, c: add_co, h: add_hco};
        sub_d = (op == OP_SUBC);
      end
      OP_DCOR: nxt = dec_res;
      OP_NOP:  ;
      default: nxt = bit_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      c_q   <= 1'b0;
      h_q   <= 1'b0;
      sub_q <= 1'b0;
    end else if (we_i) begin
      acc_q <= nxt.acc;
      c_q   <= nxt.c;
      h_q   <= nxt.h;
      sub_q <= sub_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = c_q;
  assign half_o  = h_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              carry_o,
  input logic              half_o,
  input logic              sub_i
);
  logic wr;
  assign wr = we_i && (op_i != OP_NOP);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(acc_o) && $stable(carry_o) && $stable(half_o) && $stable(sub_i));

  assert_plain_add_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (op_i == OP_ADD || op_i == OP_INC || op_i == OP_DEC)
    |=> $stable(carry_o) && $stable(half_o));

  assert_adc_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_ADC |=> !sub_i);

  assert_subc_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_SUBC |=> sub_i);

  assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_CLR |=> acc_o == '0 && $stable(carry_o) && $stable(half_o));

  assert_rrc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_RRC
    |=> acc_o[DATA_W-1] == $past(carry_o) && carry_o == $past(acc_o[0]) && $stable(half_o));

  assert_rlc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_RLC
    |=> acc_o[0] == $past(carry_o) && carry_o == $past(acc_o[DATA_W-1])
        && half_o == $past(acc_o[0]));

  assert_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_SWAP
    |=> acc_o == {$past(acc_o[NIB_W-1:0]), $past(acc_o[DATA_W-1:NIB_W])});

  assert_sc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_SC |=> carry_o && half_o && $stable(acc_o));

  assert_rc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_RC |=> !carry_o && !half_o && $stable(acc_o));

  assert_dcor_add_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_DCOR && !sub_i && carry_o |=> carry_o && $stable(half_o));

  assert_dcor_sub_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_DCOR && sub_i |=> $stable(carry_o) && $stable(half_o));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .acc_o     (acc_o),
  .carry_o   (carry_o),
  .half_o    (half_o),
  .sub_i     (sub_q)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] opd = 8'h00;
  logic [7:0] acc;
  logic       c, h;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .op_i(op),
    .operand_i(opd), .acc_o(acc), .carry_o(c), .half_o(h)
  );

  task automatic chk(input string req, input logic [7:0] a_e,
                     input logic c_e, input logic h_e);
    n_chk++;
    if (acc !== a_e || c !== c_e || h !== h_e) begin
      n_bad++;
      $display("FAIL %s: acc=%h c=%b h=%b expected acc=%h c=%b h=%b",
               req, acc, c, h, a_e, c_e, h_e);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    we = en; op = o; opd = d;
    @(negedge clk);
    we = 1'b0; op = 4'd15;
  endtask

  // clear then plain add: flags untouched
  task automatic load(input logic [7:0] v);
    run(4'd6, 8'h00);
    run(4'd0, v);
  endtask

  task automatic t_reset;
    chk("R1 reset", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    load(8'h5A); run(4'd12, 8'h00);
    run(4'd6, 8'h00, 1'b0);
    chk("R2 we low", 8'h5A, 1'b1, 1'b1);
    run(4'd15, 8'hFF);
    chk("R2 nop", 8'h5A, 1'b1, 1'b1);
  endtask

  task automatic t_add;
    load(8'hF0); run(4'd12, 8'h00);
    run(4'd0, 8'h20);
    chk("R3 add wrap", 8'h10, 1'b1, 1'b1);
    run(4'd13, 8'h00);
    load(8'hFF); run(4'd7, 8'h00);
    chk("R3 inc wrap", 8'h00, 1'b0, 1'b0);
    run(4'd8, 8'h00);
    chk("R3 dec wrap", 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic t_adc;
    run(4'd13, 8'h00); load(8'h3A);
    run(4'd1, 8'hC7);
    chk("R4 adc both carries", 8'h01, 1'b1, 1'b1);
    run(4'd12, 8'h00); load(8'h12);
    run(4'd1, 8'h03);
    chk("R4 adc carry in", 8'h16, 1'b0, 1'b0);
  endtask

  task automatic t_subc;
    run(4'd12, 8'h00); load(8'h10);
    run(4'd2, 8'h01);
    chk("R5 subc half borrow", 8'h0F, 1'b1, 1'b0);
    run(4'd14, 8'h00);
    chk("R12 dcor sub low", 8'h09, 1'b1, 1'b0);
    run(4'd12, 8'h00); load(8'h05);
    run(4'd2, 8'h07);
    chk("R5 subc full borrow", 8'hFE, 1'b0, 1'b0);
    run(4'd14, 8'h00);
    chk("R12 dcor sub both", 8'h98, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    run(4'd12, 8'h00); load(8'hCC);
    run(4'd3, 8'hAA);
    chk("R6 and", 8'h88, 1'b1, 1'b1);
    run(4'd4, 8'h11);
    chk("R6 or", 8'h99, 1'b1, 1'b1);
    run(4'd5, 8'hFF);
    chk("R6 xor", 8'h66, 1'b1, 1'b1);
    run(4'd6, 8'h00);
    chk("R6 clr", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_rot;
    load(8'h81); run(4'd12, 8'h00);
    run(4'd9, 8'h00);
    chk("R7 rrc c in", 8'hC0, 1'b1, 1'b1);
    run(4'd13, 8'h00);
    run(4'd9, 8'h00);
    chk("R7 rrc zero in", 8'h60, 1'b0, 1'b0);
    load(8'h81);
    run(4'd10, 8'h00);
    chk("R8 rlc", 8'h02, 1'b1, 1'b1);
    run(4'd10, 8'h00);
    chk("R8 rlc again", 8'h05, 1'b0, 1'b0);
  endtask

  task automatic t_swap_flags;
    load(8'h3C);
    run(4'd11, 8'h00);
    chk("R9 swap", 8'hC3, 1'b0, 1'b0);
    run(4'd12, 8'h00);
    chk("R10 sc", 8'hC3, 1'b1, 1'b1);
    run(4'd13, 8'h00);
    chk("R10 rc", 8'hC3, 1'b0, 1'b0);
  endtask

  task automatic t_dcor_add;
    run(4'd13, 8'h00); load(8'h45);
    run(4'd1, 8'h38);
    chk("R4 adc bcd", 8'h7D, 1'b0, 1'b0);
    run(4'd14, 8'h00);
    chk("R11 dcor low digit", 8'h83, 1'b0, 1'b0);
    run(4'd13, 8'h00); load(8'h99);
    run(4'd1, 8'h01);
    run(4'd14, 8'h00);
    chk("R11 dcor overflow", 8'h00, 1'b1, 1'b0);
    run(4'd13, 8'h00); load(8'h09);
    run(4'd1, 8'h09);
    run(4'd14, 8'h00);
    chk("R11 dcor half carry", 8'h18, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_hold();
    t_add();
    t_adc();
    t_subc();
    t_logic();
    t_rot();
    t_swap_flags();
    t_dcor_add();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: acc=%h expected run to finish", acc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule